// File: doc/BRIEF.md
# Shadowed PWM Comparison Update Unit

This block is one comparison unit for a running PWM channel. Software can change the compare value and the compare configuration while the channel keeps counting. Writes never touch the live compare state. They land in a value shadow and a mode shadow. The live ("active") registers are reloaded from the shadows only at a synchronised boundary.

A boundary is a cycle on which the PWM period ends and the internal update-period counter has reached the update period held in the active mode. The update is armed in two stages. A value write on its own arms nothing. A later mode write sets a pending flag, and the next boundary moves both shadows into the active registers together.

While enabled, the unit compares the channel counter with the active compare value and emits a one-cycle match pulse. Register decoding on the bus and the waveform generator are outside this block.

Top module: `pwm_cmp_update`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `act_value`, `act_mode` and `match` are all zero. The shadows, the pending flag and the update-period counter are also cleared.
- R2: A write (`wr_en` high) updates only a shadow register. `act_value` and `act_mode` do not change unless a boundary occurs.
- R3: The update-period counter advances by one on each cycle with `period_end` high. A boundary is a cycle with `period_end` high and the counter equal to the active period field; on that cycle the counter returns to 0. With a pending update, the active registers load on the clock edge that ends the boundary cycle.
- R4: A value write (`wr_sel`=0) that is not followed by a mode write never reaches the active registers, even across boundaries.
- R5: When the shadows are written several times before a boundary, the active registers receive the last value and the last mode written.
- R6: At a boundary with no pending update, the active registers keep their contents.
- R7: A mode write on the same cycle as a transfer does not affect that transfer. It is kept as a new pending update and is loaded at the next boundary.
- R8: `match` is high for the one cycle that follows a cycle on which the active enable bit is 1 and `chan_cnt` equals `act_value`. With the enable bit at 0 it stays low.
- R9: Write encoding: `wr_sel`=0 writes `wr_data[15:0]` as the compare value. `wr_sel`=1 writes the mode, with enable = `wr_data[0]`, update period = `wr_data[7:4]` and trigger divisor = `wr_data[11:8]`. `act_mode` packs these as divisor in [8:5], period in [4:1] and enable in [0].
- R10: After a transfer, the newly loaded period field sets the counter limit for the following boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 1 | 0 = value shadow, 1 = mode shadow |
| wr_data | input | 16 | Write data |
| period_end | input | 1 | One-cycle pulse at the end of each PWM period |
| chan_cnt | input | 16 | PWM channel counter |
| act_value | output | 16 | Active compare value |
| act_mode | output | 9 | Active mode {divisor, period, enable} |
| match | output | 1 | Registered compare match pulse |

## Verification
The checker watches, on every cycle, the properties that can be stated locally. The active registers may change only after a period end. The update-period counter never passes the active period. A match needs the enable bit and an equal counter on the cycle before. The reset values must hold.

The arming order cannot be seen from a single cycle, so the bench scenarios cover it. These include a value write with no mode write, repeated writes where the last one wins, a boundary with nothing pending, and a mode write that collides with a transfer. The scenarios also show that a new period changes how many period ends pass before the next load.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam int PER_W  = 4;
  localparam int DIV_W  = 4;
  localparam int MODE_W = 1 + PER_W + DIV_W;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] period;
    logic             en;
  } mode_t;

  // Mode field positions in a write word: enable bit 0, period at 4, divisor at 8.
  function automatic mode_t decode_mode(input logic [15:0] d);
    mode_t m;
    m.en     = d[0];
    m.period = d[4 +: PER_W];
    m.div    = d[8 +: DIV_W];
    return m;
  endfunction
endpackage

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow
  import pwm_cmp_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [VAL_W-1:0] wr_data,
  input  logic             xfer,
  output logic [VAL_W-1:0] sh_value,
  output mode_t            sh_mode,
  output logic             pending
);
  logic mode_wr, value_wr;
  assign mode_wr  = wr_en &  wr_sel;
  assign value_wr = wr_en & ~wr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_value <= '0;
      sh_mode  <= '0;
      pending  <= 1'b0;
    end else begin
      if (value_wr) sh_value <= wr_data;
      if (mode_wr)  sh_mode  <= decode_mode(wr_data[15:0]);
      // A mode write wins over the clear, so a colliding write stays armed.
      if (mode_wr)   pending <= 1'b1;
      else if (xfer) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_cmp_period.sv
module pwm_cmp_period
  import pwm_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             period_end,
  input  logic [PER_W-1:0] limit,
  output logic             boundary,
  output logic [PER_W-1:0] cnt
);
  assign boundary = period_end && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (boundary)   cnt <= '0;
    else if (period_end) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_cmp_match.sv
module pwm_cmp_match #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [VAL_W-1:0] value,
  input  logic [VAL_W-1:0] chan_cnt,
  output logic             match
);
  always_ff @(posedge clk) begin
    if (rst) match <= 1'b0;
    else     match <= en && (chan_cnt == value);
  end
endmodule

// File: rtl/pwm_cmp_update.sv
module pwm_cmp_update
  import pwm_cmp_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [VAL_W-1:0]  wr_data,
  input  logic              period_end,
  input  logic [VAL_W-1:0]  chan_cnt,
  output logic [VAL_W-1:0]  act_value,
  output logic [MODE_W-1:0] act_mode,
  output logic              match
);
  logic [VAL_W-1:0] sh_value;
  mode_t            sh_mode;
  mode_t            act_m;
  logic             pending;
  logic             boundary;
  logic             xfer;
  logic [PER_W-1:0] upd_cnt;

  assign xfer = boundary && pending;

  pwm_cmp_shadow #(.VAL_W(VAL_W)) u_shadow (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer(xfer), .sh_value(sh_value), .sh_mode(sh_mode), .pending(pending)
  );

  pwm_cmp_period u_period (
    .clk(clk), .rst(rst), .period_end(period_end), .limit(act_m.period),
    .boundary(boundary), .cnt(upd_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_value <= '0;
      act_m     <= '0;
    end else if (xfer) begin
      act_value <= sh_value;
      act_m     <= sh_mode;
    end
  end

  assign act_mode = act_m;

  pwm_cmp_match #(.VAL_W(VAL_W)) u_match (
    .clk(clk), .rst(rst), .en(act_m.en), .value(act_value),
    .chan_cnt(chan_cnt), .match(match)
  );
endmodule

// File: rtl/pwm_cmp_update_chk.sv
module pwm_cmp_update_chk
  import pwm_cmp_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              period_end,
  input logic [VAL_W-1:0]  chan_cnt,
  input logic [VAL_W-1:0]  act_value,
  input logic [MODE_W-1:0] act_mode,
  input logic              match,
  input logic [PER_W-1:0]  upd_cnt
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (act_value == '0 && act_mode == '0 && !match));

  assert_load_after_period_end_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_value) || !$stable(act_mode)) |-> $past(period_end));

  assert_counter_within_limit_R10: assert property (@(posedge clk) disable iff (rst)
    upd_cnt <= act_mode[PER_W:1]);

  assert_match_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    match |-> $past(act_mode[0]));

  assert_match_needs_equal_R8: assert property (@(posedge clk) disable iff (rst)
    match |-> ($past(chan_cnt) == $past(act_value)));
endmodule

bind pwm_cmp_update pwm_cmp_update_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst(rst), .period_end(period_end), .chan_cnt(chan_cnt),
  .act_value(act_value), .act_mode(act_mode), .match(match), .upd_cnt(upd_cnt)
);

// File: tb/pwm_cmp_update_test.sv
module pwm_cmp_update_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0, period_end = 1'b0;
  logic [15:0] wr_data = '0, chan_cnt = '0;
  logic [15:0] act_value;
  logic [8:0]  act_mode;
  logic        match;

  always #4 clk = ~clk;  // 125 MHz

  pwm_cmp_update uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .period_end(period_end), .chan_cnt(chan_cnt),
    .act_value(act_value), .act_mode(act_mode), .match(match)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Scoreboard: expected {value, div, period, en, match} per clock
  logic [25:0] exp_q[$];
  string       tag_q[$];

  // Reference state from the requirements
  logic [15:0] m_val = '0, s_val = '0;
  logic        m_en = 0, s_en = 0, m_pend = 0, m_match = 0;
  logic [3:0]  m_per = '0, m_div = '0, s_per = '0, s_div = '0, m_cnt = '0;
  logic [15:0] ccnt = '0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic sel, input logic [15:0] d, input logic pe);
    logic bnd, nm;
    wr_en = we; wr_sel = sel; wr_data = d; period_end = pe; chan_cnt = ccnt;
    bnd = pe && (m_cnt == m_per);
    nm  = m_en && (ccnt == m_val);
    if (bnd && m_pend) begin
      m_val = s_val; m_en = s_en; m_per = s_per; m_div = s_div;
    end
    if (pe) m_cnt = bnd ? 4'd0 : m_cnt + 4'd1;
    if (we && sel) m_pend = 1'b1;
    else if (bnd)  m_pend = 1'b0;
    if (we) begin
      if (sel) begin s_en = d[0]; s_per = d[7:4]; s_div = d[11:8]; end
      else s_val = d;
    end
    m_match = nm;
    @(posedge clk);
    exp_q.push_back({m_val, m_div, m_per, m_en, m_match});
    tag_q.push_back(cur_req);
    @(negedge clk);
    ccnt = (ccnt == 16'd19) ? 16'd0 : ccnt + 16'd1;
    wr_en = 1'b0; period_end = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic pulse();
    step(1'b0, 1'b0, 16'h0, 1'b1);
  endtask

  task automatic count_matches(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b0, 16'h0, 1'b0);
      if (match) c++;
    end
  endtask

  // Monitor: compares each clock's outputs against the queued expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [25:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({act_value, act_mode, match} !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, {act_value, act_mode, match}, e);
      end
    end
  end

  initial begin
    int c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {act_value, act_mode, match}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {act_value, act_mode, match}, 32'h0);

    // R2: value write stays in the shadow
    cur_req = "R2";
    step(1'b1, 1'b0, 16'd5, 1'b0);
    idle(3);
    chk("R2", act_value, 32'd0);

    // R4: value write alone, boundaries pass (period 0), nothing loads
    cur_req = "R4";
    pulse(); pulse();
    chk("R4", act_value, 32'd0);

    // R3 / R9: mode write arms; load waits for period end
    cur_req = "R3";
    step(1'b1, 1'b1, 16'h0321, 1'b0);
    idle(2);
    chk("R3", act_value, 32'd0);
    pulse();
    chk("R3", act_value, 32'd5);
    chk("R9", act_mode, {23'd0, 4'd3, 4'd2, 1'b1});

    // R8: one match per 20-cycle sweep of chan_cnt
    cur_req = "R8";
    count_matches(20, c);
    chk("R8", c, 32'd1);

    // R10: period 2 now active, load on third period end
    cur_req = "R10";
    step(1'b1, 1'b0, 16'd7, 1'b0);
    step(1'b1, 1'b1, 16'h0121, 1'b0);
    pulse(); chk("R10", act_value, 32'd5);
    pulse(); chk("R10", act_value, 32'd5);
    pulse(); chk("R10", act_value, 32'd7);

    // R5: last writes win
    cur_req = "R5";
    step(1'b1, 1'b0, 16'd8, 1'b0);
    step(1'b1, 1'b0, 16'd9, 1'b0);
    step(1'b1, 1'b1, 16'h0401, 1'b0);
    step(1'b1, 1'b1, 16'h0201, 1'b0);
    pulse(); pulse(); pulse();
    chk("R5", act_value, 32'd9);
    chk("R5", act_mode, {23'd0, 4'd2, 4'd0, 1'b1});

    // R6: boundary with nothing pending
    cur_req = "R6";
    pulse();
    chk("R6", act_value, 32'd9);
    cur_req = "R4";
    step(1'b1, 1'b0, 16'd11, 1'b0);
    pulse();
    chk("R4", act_value, 32'd9);

    // R7: mode write colliding with a transfer
    cur_req = "R7";
    step(1'b1, 1'b1, 16'h0001, 1'b0);
    step(1'b1, 1'b1, 16'h0301, 1'b1);
    chk("R7", act_value, 32'd11);
    chk("R7", act_mode, {23'd0, 4'd0, 4'd0, 1'b1});
    pulse();
    chk("R7", act_mode, {23'd0, 4'd3, 4'd0, 1'b1});

    // R8: disabled, no matches even with value inside the sweep
    cur_req = "R8";
    step(1'b1, 1'b0, 16'd5, 1'b0);
    step(1'b1, 1'b1, 16'h0000, 1'b0);
    pulse();
    count_matches(25, c);
    chk("R8", c, 32'd0);

    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule